// File: doc/BRIEF.md
# Byte-wide reset control port

This block sits on a simple I/O bus and owns one 8-bit register at a single port address (0xCF9 by default). Software writes a byte to it and can read the same byte back. Writing a byte whose bit 2 is 1 while the stored bit 2 is 0 asks for a system reset. The block raises a one-cycle request pulse, and beside it gives the reset type taken from bit 1 of the same write (0 soft, 1 hard). The block only raises the request. Other logic decides what each reset type does, and both types may lead to the same action.

Only one-byte accesses are accepted. A read or write of any other width at the port address raises an error flag and leaves the register alone. Accesses at other addresses are ignored. All outputs are registered and appear in the cycle after the access.

Top module: `rst_ctl_port`

## Requirements
- R1: On reset (rst_ni low) the stored byte is 0x00, and rdata_o, err_o, rst_req_o and rst_hard_o are all 0.
- R2: A write with size_i = 0 (one byte) at the port address stores wdata_i[7:0]. A one-byte read there sets rdata_o in the next cycle to the last byte stored, in bits 7:0, with all upper bits 0.
- R3: An access (wr_i or rd_i) at the port address with size_i other than 0 (1 = two bytes, 2 = four bytes, 3 = reserved) sets err_o for exactly the next cycle. It leaves the stored byte unchanged and causes no reset request.
- R4: Accesses at any other address cause no error and no reset request, and leave the stored byte unchanged.
- R5: A valid one-byte write with bit 2 = 1, while the stored bit 2 is 0, sets rst_req_o for exactly the next cycle.
- R6: A valid write with bit 2 = 1 while the stored bit 2 is already 1 causes no pulse. A pulse fires again only after bit 2 has been written back to 0.
- R7: While rst_req_o is 1, rst_hard_o equals bit 1 of the write that caused the pulse. At all other times rst_hard_o is 0.
- R8: rdata_o is 0 in every cycle except the one that follows a valid one-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | I/O port address of the access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| size_i | input | 2 | Access width: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| wdata_i | input | DATA_W | Write data; the low byte is stored |
| rdata_o | output | DATA_W | Read data, valid in the cycle after a valid read |
| err_o | output | 1 | Access size error, cycle after the access |
| rst_req_o | output | 1 | One-cycle system reset request |
| rst_hard_o | output | 1 | Reset type during the request: 1 hard, 0 soft |

## Verification
The assertions assume that wr_i and rd_i are never high in the same cycle, and that every strobe lasts a single cycle. The checks on err_o and rdata_o are built on that. The bench drives each access for exactly one cycle and then returns every input to idle, so two accesses never overlap. It also holds every input at zero while reset is asserted, so the first $past samples after reset are idle values.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic wr_ok;
    logic rd_ok;
    logic bad;
  } dec_t;
endpackage

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
  import rst_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  acc_size_e         size_i,
  output dec_t              dec_o
);
  logic hit, byte_ok;

  assign hit     = (addr_i == PORT_ADDR);
  assign byte_ok = (size_i == SZ_BYTE);

  always_comb begin
    dec_o.wr_ok = hit & wr_i & byte_ok;
    // write wins if both strobes appear
    dec_o.rd_ok = hit & rd_i & ~wr_i & byte_ok;
    dec_o.bad   = hit & (wr_i | rd_i) & ~byte_ok;
  end
endmodule

// File: rtl/rst_ctl_store.sv
module rst_ctl_store
  import rst_ctl_pkg::*;
#(
  parameter int REQ_BIT  = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wbyte_i,
  output logic [REG_W-1:0] reg_o,
  output logic             fire_o,
  output logic             hard_o
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= wbyte_i;
  end

  // rising edge of the request bit, old value against new
  assign fire_o = we_i & wbyte_i[REQ_BIT] & ~reg_q[REQ_BIT];
  assign hard_o = wbyte_i[TYPE_BIT];
  assign reg_o  = reg_q;
endmodule

// File: rtl/rst_ctl_resp.sv
module rst_ctl_resp
  import rst_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ok_i,
  input  logic              bad_i,
  input  logic              fire_i,
  input  logic              hard_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              req_o,
  output logic              hard_o
);
  localparam int PAD_W = DATA_W - REG_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      req_o   <= 1'b0;
      hard_o  <= 1'b0;
    end else begin
      rdata_o <= rd_ok_i ? {{PAD_W{1'b0}}, reg_i} : '0;
      err_o   <= bad_i;
      req_o   <= fire_i;
      hard_o  <= fire_i & hard_i;
    end
  end
endmodule

// File: rtl/rst_ctl_port.sv
module rst_ctl_port
  import rst_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int REQ_BIT  = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              rst_req_o,
  output logic              rst_hard_o
);
  dec_t             dec;
  logic [REG_W-1:0] reg_val;
  logic             fire, hard;

  rst_ctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .size_i (acc_size_e'(size_i)),
    .dec_o  (dec)
  );

  rst_ctl_store #(.REQ_BIT(REQ_BIT), .TYPE_BIT(TYPE_BIT)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dec.wr_ok),
    .wbyte_i (wdata_i[REG_W-1:0]),
    .reg_o   (reg_val),
    .fire_o  (fire),
    .hard_o  (hard)
  );

  rst_ctl_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_ok_i (dec.rd_ok),
    .bad_i   (dec.bad),
    .fire_i  (fire),
    .hard_i  (hard),
    .reg_i   (reg_val),
    .rdata_o (rdata_o),
    .err_o   (err_o),
    .req_o   (rst_req_o),
    .hard_o  (rst_hard_o)
  );
endmodule

// File: rtl/rst_ctl_port_chk.sv
module rst_ctl_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int REQ_BIT  = 2,
  parameter int TYPE_BIT = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              rst_req_o,
  input logic              rst_hard_o
);
  logic hit, access, byte_acc;
  assign hit      = (addr_i == PORT_ADDR);
  assign access   = wr_i | rd_i;
  assign byte_acc = (size_i == 2'd0);

  assert_err_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && access && !byte_acc) |=> err_o);

  assert_err_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(hit && access && !byte_acc));

  assert_req_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(hit && wr_i && byte_acc && wdata_i[REQ_BIT]));

  assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_hard_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_o |-> !rst_hard_o);

  assert_hard_type_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rst_hard_o == $past(wdata_i[TYPE_BIT])));

  assert_rdata_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hit && rd_i && !wr_i && byte_acc) |-> (rdata_o == '0));

  assert_rdata_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[DATA_W-1:8] == '0));
endmodule

bind rst_ctl_port rst_ctl_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
  .REQ_BIT(REQ_BIT), .TYPE_BIT(TYPE_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
  .rst_req_o(rst_req_o), .rst_hard_o(rst_hard_o)
);

// File: tb/sim_rst_ctl_port.sv
module sim_rst_ctl_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o, rst_req_o, rst_hard_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] s_rdata;
  logic        s_err, s_req, s_hard;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rst_ctl_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
    .rst_req_o(rst_req_o), .rst_hard_o(rst_hard_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one-cycle access; outputs sampled in the cycle after it
  task automatic access(input logic [15:0] a, input logic w, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_i = w; rd_i = ~w; size_i = sz; wdata_i = d;
    @(negedge clk_i);
    addr_i = '0; wr_i = 1'b0; rd_i = 1'b0; size_i = '0; wdata_i = '0;
    s_rdata = rdata_o; s_err = err_o; s_req = rst_req_o; s_hard = rst_hard_o;
  endtask

  task automatic rd_byte(output logic [31:0] v);
    access(PORT, 1'b0, 2'd0, '0);
    v = s_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rdata", rdata_o, 0);
    chk("R1 err", {31'b0, err_o}, 0);
    chk("R1 req", {31'b0, rst_req_o}, 0);
    chk("R1 hard", {31'b0, rst_hard_o}, 0);
    rd_byte(v);
    chk("R1 stored", v, 0);
  endtask

  task automatic t_store;
    logic [31:0] v;
    access(PORT, 1'b1, 2'd0, 32'hFFFF_FF3A);
    chk("R5 no pulse bit2 clear", {31'b0, s_req}, 0);
    chk("R3 no err byte", {31'b0, s_err}, 0);
    rd_byte(v);
    chk("R2 readback", v, 32'h3A);
    @(negedge clk_i);
    chk("R8 rdata idle", rdata_o, 0);
  endtask

  task automatic t_size;
    logic [31:0] v;
    access(PORT, 1'b1, 2'd1, 32'h0000_00F7);
    chk("R3 err half write", {31'b0, s_err}, 1);
    chk("R3 no pulse", {31'b0, s_req}, 0);
    @(negedge clk_i);
    chk("R3 err one cycle", {31'b0, err_o}, 0);
    access(PORT, 1'b1, 2'd2, 32'h0000_0004);
    chk("R3 err word write", {31'b0, s_err}, 1);
    access(PORT, 1'b0, 2'd3, '0);
    chk("R3 err rsvd read", {31'b0, s_err}, 1);
    chk("R8 rdata on bad read", s_rdata, 0);
    rd_byte(v);
    chk("R3 unchanged", v, 32'h3A);
  endtask

  task automatic t_addr;
    logic [31:0] v;
    access(16'hCF8, 1'b1, 2'd0, 32'h0000_00FF);
    chk("R4 no err", {31'b0, s_err}, 0);
    chk("R4 no pulse", {31'b0, s_req}, 0);
    access(16'hCFA, 1'b0, 2'd1, '0);
    chk("R4 no err size", {31'b0, s_err}, 0);
    chk("R8 rdata other addr", s_rdata, 0);
    rd_byte(v);
    chk("R4 unchanged", v, 32'h3A);
  endtask

  task automatic t_pulse;
    logic [31:0] v;
    access(PORT, 1'b1, 2'd0, 32'h04);
    chk("R5 pulse soft", {31'b0, s_req}, 1);
    chk("R7 soft type", {31'b0, s_hard}, 0);
    @(negedge clk_i);
    chk("R5 pulse width", {31'b0, rst_req_o}, 0);
    access(PORT, 1'b1, 2'd0, 32'h06);
    chk("R6 no refire", {31'b0, s_req}, 0);
    chk("R7 hard idle", {31'b0, s_hard}, 0);
    rd_byte(v);
    chk("R2 readback 06", v, 32'h06);
    access(PORT, 1'b1, 2'd0, 32'h00);
    chk("R6 clear no pulse", {31'b0, s_req}, 0);
    access(PORT, 1'b1, 2'd0, 32'h06);
    chk("R6 refire", {31'b0, s_req}, 1);
    chk("R7 hard type", {31'b0, s_hard}, 1);
    @(negedge clk_i);
    chk("R7 hard drops", {31'b0, rst_hard_o}, 0);
    access(PORT, 1'b1, 2'd0, 32'hFF);
    chk("R6 still set no pulse", {31'b0, s_req}, 0);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_store();
    t_size();
    t_addr();
    t_pulse();
    done = 1;
    finish_up();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule